// File: doc/BRIEF.md
# Tracking-Bank Gain Compensation Selector

This block sits in the fine-tuning path of a digitally controlled oscillator. The fine tracking capacitors are built as two stacked sets of about equal size. When both sets follow the tracking word, each tracking step moves the oscillator about twice as far as when only the second set follows it. A fixed capacitor step moves the frequency roughly with the cube of frequency. The selector therefore halves the per-step capacitance in the upper part of the tuning range. This keeps the fine-tuning gain within a narrower band.

On every reference clock edge, the block compares the coarse process/voltage/temperature bank code with a programmable threshold code. A polarity input states whether a larger code means a higher or a lower oscillator frequency. The result picks full-gain mode (both sets driven) or half-gain mode (second set only). Once the loop reports lock, the coarse code no longer moves. The block then freezes its choice until lock drops. With the enable low, it always drives both sets.

All outputs leave registers that update on the same edge. The capacitor bank therefore never sees one set switched while the other still carries a stale word.

Top module: `tracking_gain_comp`

## Requirements
- R1: While reset is high at a clock edge, both set words and the status flag are zero after that edge.
- R2: With polarity 0 (larger code means higher frequency), enable high and lock low, a coarse code strictly greater than the threshold selects half-gain mode. In half-gain mode, set 0 is all zeros, set 1 carries the tracking word and status is 1. Any other code selects full-gain mode: both sets carry the tracking word and status is 0.
- R3: With polarity 1 (larger code means lower frequency), enable high and lock low, a coarse code strictly less than the threshold selects half-gain mode. Any other code selects full-gain mode.
- R4: A coarse code equal to the threshold always selects full-gain mode, for either polarity.
- R5: Mode, status and both set words change together, one reference clock edge after the inputs that caused them.
- R6: With enable low, the block is in full-gain mode whatever the codes, polarity and lock.
- R7: On the first edge where enable and lock are both high, the mode is taken from that edge's comparison. At later edges with enable and lock still high, the mode is held, whatever the code, threshold or polarity do.
- R8: The edge after lock goes low, the block compares again and follows the current codes.
- R9: Set 1 always carries the tracking word from the previous edge, bit for bit, in every mode. The 5-bit word is thermometer coded, with ones filled from bit 0 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_code | input | CODE_W | Coarse process/voltage/temperature bank code |
| thresh_code | input | CODE_W | Programmable threshold code |
| polarity | input | 1 | 0: larger code is higher frequency; 1: larger code is lower frequency |
| enable | input | 1 | 1 enables compensation; 0 forces full-gain mode |
| lock | input | 1 | Loop lock indication |
| trk_word | input | TRK_W | Thermometer tracking word |
| set0_word | output | TRK_W | Gated word for the first tracking capacitor set |
| set1_word | output | TRK_W | Word for the second tracking capacitor set |
| half_gain | output | 1 | Status: 1 when only the second set is driven |

## Verification
A wrong mode register shows up one edge later as set 0 dropping to zero or copying set 1. The status flag disagrees with the expected comparison at the same sample. A broken freeze flag shows up a cycle after the coarse code crosses the threshold during lock: the mode flips when it should hold. A stuck freeze after lock drops shows up as a stale mode on the first unlocked compare. Sweeping every code, threshold and polarity in a small configuration exposes comparator errors at the equality boundary and polarity inversions. Each of these is seen after a single edge.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  typedef enum logic {
    GAIN_FULL = 1'b0,
    GAIN_HALF = 1'b1
  } gain_mode_e;
endpackage

// File: rtl/code_compare.sv
module code_compare #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] coarse_code,
  input  logic [CODE_W-1:0] thresh_code,
  input  logic              polarity,
  output logic              above_thr
);
  // one magnitude comparator; polarity swaps its operands
  logic [CODE_W-1:0] op_a, op_b;

  always_comb begin
    op_a      = polarity ? thresh_code : coarse_code;
    op_b      = polarity ? coarse_code : thresh_code;
    above_thr = (op_a > op_b);
  end

  // R4: equal codes never report an above-threshold frequency
  always_comb begin
    if (coarse_code == thresh_code)
      a_r4_equal_is_below: assert (!above_thr);
  end
endmodule

// File: rtl/gain_mode_ctl.sv
module gain_mode_ctl
  import tgc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       lock,
  input  logic       above_thr,
  output gain_mode_e mode_next,
  output gain_mode_e mode_q
);
  logic frozen_q;

  always_comb begin
    if (!enable)
      mode_next = GAIN_FULL;
    else if (lock && frozen_q)
      mode_next = mode_q;
    else
      mode_next = above_thr ? GAIN_HALF : GAIN_FULL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= GAIN_FULL;
      frozen_q <= 1'b0;
    end else begin
      mode_q   <= mode_next;
      frozen_q <= lock && enable;
    end
  end

  // R7: once a locked sample has been taken, the mode holds while locked
  a_r7_hold_when_locked: assert property (@(posedge clk) disable iff (rst)
    (enable && lock && frozen_q) |=> $stable(mode_q));

  // R6: disabled means full gain on the next edge
  a_r6_disable_full: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (mode_q == GAIN_FULL));

  // R8: freeze flag is clear right after lock is low
  a_r8_unlock_clears: assert property (@(posedge clk) disable iff (rst)
    !lock |=> !frozen_q);
endmodule

// File: rtl/trk_gate.sv
module trk_gate
  import tgc_pkg::*;
#(
  parameter int TRK_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  gain_mode_e       mode_next,
  input  logic [TRK_W-1:0] trk_word,
  output logic [TRK_W-1:0] set0_q,
  output logic [TRK_W-1:0] set1_q
);
  logic keep_set0;

  always_comb keep_set0 = (mode_next == GAIN_FULL);

  for (genvar b = 0; b < TRK_W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        set0_q[b] <= 1'b0;
        set1_q[b] <= 1'b0;
      end else begin
        set0_q[b] <= trk_word[b] & keep_set0;
        set1_q[b] <= trk_word[b];
      end
    end
  end
endmodule

// File: rtl/tracking_gain_comp.sv
module tracking_gain_comp
  import tgc_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int TRK_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] coarse_code,
  input  logic [CODE_W-1:0] thresh_code,
  input  logic              polarity,
  input  logic              enable,
  input  logic              lock,
  input  logic [TRK_W-1:0]  trk_word,
  output logic [TRK_W-1:0]  set0_word,
  output logic [TRK_W-1:0]  set1_word,
  output logic              half_gain
);
  logic       above_thr;
  gain_mode_e mode_next;
  gain_mode_e mode_q;

  code_compare #(.CODE_W(CODE_W)) u_cmp (
    .coarse_code (coarse_code),
    .thresh_code (thresh_code),
    .polarity    (polarity),
    .above_thr   (above_thr)
  );

  gain_mode_ctl u_mode (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .lock      (lock),
    .above_thr (above_thr),
    .mode_next (mode_next),
    .mode_q    (mode_q)
  );

  trk_gate #(.TRK_W(TRK_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .mode_next (mode_next),
    .trk_word  (trk_word),
    .set0_q    (set0_word),
    .set1_q    (set1_word)
  );

  always_comb half_gain = (mode_q == GAIN_HALF);

  // R1: reset clears every output
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (set0_word == '0 && set1_word == '0 && !half_gain));

  // R5: in half-gain mode the first set is idle
  a_r5_half_set0_idle: assert property (@(posedge clk) disable iff (rst)
    half_gain |-> (set0_word == '0));

  // R5: in full-gain mode both sets carry the same word
  a_r5_full_sets_match: assert property (@(posedge clk) disable iff (rst)
    !half_gain |-> (set0_word == set1_word));

  // R9: set 1 follows the tracking word with one edge of delay
  a_r9_set1_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (set1_word == $past(trk_word)));
endmodule

// File: tb/tb_tracking_gain_comp.sv
module tb_tracking_gain_comp;
  localparam int CW = 4;
  localparam int TW = 5;

  logic          clk = 1'b0;
  logic          rst;
  logic [CW-1:0] coarse_code, thresh_code;
  logic          polarity, enable, lock;
  logic [TW-1:0] trk_word;
  logic [TW-1:0] set0_word, set1_word;
  logic          half_gain;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tracking_gain_comp #(.CODE_W(CW), .TRK_W(TW)) dut (
    .clk(clk), .rst(rst), .coarse_code(coarse_code), .thresh_code(thresh_code),
    .polarity(polarity), .enable(enable), .lock(lock), .trk_word(trk_word),
    .set0_word(set0_word), .set1_word(set1_word), .half_gain(half_gain)
  );

  function automatic logic [TW-1:0] therm(input int n);
    return TW'((1 << n) - 1);
  endfunction

  task automatic chk(input bit exp_half, input logic [TW-1:0] exp_trk, input string req);
    logic [TW-1:0] exp0;
    exp0 = exp_half ? '0 : exp_trk;
    checks++;
    if (half_gain !== exp_half || set1_word !== exp_trk || set0_word !== exp0) begin
      errors++;
      $display("FAIL %s: got half=%b set0=%b set1=%b, expected half=%b set0=%b set1=%b",
               req, half_gain, set0_word, set1_word, exp_half, exp0, exp_trk);
    end
  endtask

  // drive between edges, let one posedge pass, sample at the next negedge
  task automatic step(input logic [CW-1:0] c, input logic [CW-1:0] t, input logic p,
                      input logic en, input logic lk, input logic [TW-1:0] w);
    coarse_code = c; thresh_code = t; polarity = p;
    enable = en; lock = lk; trk_word = w;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit eh;
    rst = 1'b1;
    coarse_code = '0; thresh_code = '0; polarity = 0; enable = 1; lock = 0;
    trk_word = therm(5);
    @(negedge clk);
    @(negedge clk);
    chk(1'b0, '0, "R1 reset clears outputs");
    rst = 1'b0;

    // exhaustive sweep of code, threshold and polarity (R2, R3, R4, R5, R9)
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < (1 << CW); c++) begin
        for (int t = 0; t < (1 << CW); t++) begin
          step(CW'(c), CW'(t), p[0], 1'b1, 1'b0, therm((c + t) % 6));
          eh = (p == 0) ? (c > t) : (c < t);
          if (c == t)
            chk(eh, therm((c + t) % 6), "R4 equal codes give full gain");
          else if (p == 0)
            chk(eh, therm((c + t) % 6), "R2 polarity 0 compare");
          else
            chk(eh, therm((c + t) % 6), "R3 polarity 1 compare");
        end
      end
    end

    // R5: mode change and words arrive on the same edge
    step(4'd2, 4'd8, 1'b0, 1'b1, 1'b0, therm(4));
    chk(1'b0, therm(4), "R5 full before switch");
    step(4'd9, 4'd8, 1'b0, 1'b1, 1'b0, therm(3));
    chk(1'b1, therm(3), "R5 half one edge later");

    // R6: disable forces full gain for codes that would select half
    for (int c = 9; c < 16; c++) begin
      step(CW'(c), 4'd8, 1'b0, 1'b0, c[0], therm(c % 6));
      chk(1'b0, therm(c % 6), "R6 disabled gives full gain");
    end

    // R7: lock taken while above, then held as codes move
    step(4'd12, 4'd5, 1'b0, 1'b1, 1'b1, therm(2));
    chk(1'b1, therm(2), "R7 sample on lock edge");
    for (int k = 0; k < 6; k++) begin
      step(CW'(k), 4'd5, k[0], 1'b1, 1'b1, therm(k));
      chk(1'b1, therm(k), "R7 held while locked, R9 word passes");
    end
    // R8: lock drops, comparison resumes
    step(4'd1, 4'd5, 1'b0, 1'b1, 1'b0, therm(5));
    chk(1'b0, therm(5), "R8 compare after unlock");

    // R7: lock taken while below, then held as code goes above
    step(4'd3, 4'd5, 1'b0, 1'b1, 1'b1, therm(1));
    chk(1'b0, therm(1), "R7 sample below on lock edge");
    step(4'd15, 4'd0, 1'b0, 1'b1, 1'b1, therm(3));
    chk(1'b0, therm(3), "R7 held full while locked");
    // enable drop while locked, then re-enable: new sample, then frozen
    step(4'd15, 4'd0, 1'b0, 1'b0, 1'b1, therm(3));
    chk(1'b0, therm(3), "R6 disabled during lock");
    step(4'd15, 4'd0, 1'b0, 1'b1, 1'b1, therm(4));
    chk(1'b1, therm(4), "R7 fresh sample after re-enable");
    step(4'd0, 4'd15, 1'b0, 1'b1, 1'b1, therm(4));
    chk(1'b1, therm(4), "R7 frozen after re-enable");
    step(4'd0, 4'd15, 1'b0, 1'b1, 1'b0, therm(0));
    chk(1'b0, therm(0), "R8 unlock follows codes");

    // R1: reset mid-run clears a half-gain state
    step(4'd15, 4'd0, 1'b0, 1'b1, 1'b0, therm(5));
    chk(1'b1, therm(5), "R2 half before reset");
    rst = 1'b1;
    step(4'd15, 4'd0, 1'b0, 1'b1, 1'b0, therm(5));
    chk(1'b0, '0, "R1 reset mid-run");
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule